// File: doc/BRIEF.md
# ARINC 429 FIFO-Fed Serial Transmitter

This block takes 32-bit ARINC 429 words from a 16-bit host bus and sends them as a return-to-zero serial stream on two complementary line outputs. The host writes each word in two halves. A first strobe captures the lower half. A second strobe captures the upper half and appends the whole word to a 32-entry queue. Flags report when the queue is empty and idle, when it is half full and when it is full.

While the send enable is high and words are queued, the serializer takes one word at a time and shifts it out starting with ARINC bit 1. Each bit is a data half followed by a null half. Consecutive words are separated by a quiet gap four bit times long. A rate select sets the half-bit length to 5 or 40 clocks. Bit 32 can be sent as loaded, or it can be replaced by an odd or even parity bit. Rate and parity settings are sampled when a word starts, so they stay fixed for that whole word.

Top module: `a429_word_tx`

## Requirements
- R1: A strobe on `lo_stb_i` captures `data_i` as ARINC bits 1..16 (`data_i[0]` = bit 1). A later strobe on `hi_stb_i` captures `data_i` as bits 17..32 and appends the word. Nothing is queued before the second strobe.
- R2: A `hi_stb_i` strobe that is not preceded by a `lo_stb_i` strobe since the last append is ignored.
- R3: `full_o` is high when 32 words are stored. Appends made while full are ignored and leave the stored words unchanged.
- R4: `half_o` is high exactly when 16 or more words are stored.
- R5: `ready_o` is high when the queue is empty and no bit is being shifted. It drops after an append. It rises once the null half of the last bit of the last word has ended.
- R6: Each bit is H clocks of data followed by H clocks of null. H is 5 when `slow_i`=0 and 40 when `slow_i`=1. During data a one drives `line_hi_o` high and a zero drives `line_lo_o` high. Both outputs are low during null and during the gap.
- R7: Bits go out in order from ARINC bit 1 to bit 32, that is, from stored bit 0 to bit 31.
- R8: With `par_en_i`=1, bit 32 is replaced so that the total number of ones in the 32 bits is odd when `par_even_i`=0 and even when `par_even_i`=1. With `par_en_i`=0, bit 32 is sent as loaded.
- R9: Between two back-to-back words there are exactly 8H clocks with both outputs low.
- R10: With a word queued, the first data half starts on the clock edge at which `send_en_i` is sampled high. No word starts while `send_en_i` is low. A word in progress always completes.
- R11: Reset clears the queue and stops any transmission. After reset `ready_o`=1, `half_o`=0, `full_o`=0 and both line outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 16 | Host data half-word |
| lo_stb_i | input | 1 | Capture lower half (bits 1..16) |
| hi_stb_i | input | 1 | Capture upper half and append word |
| send_en_i | input | 1 | Allow words to start |
| slow_i | input | 1 | 0: 5-clock half bit, 1: 40-clock half bit |
| par_en_i | input | 1 | Replace bit 32 with parity |
| par_even_i | input | 1 | Parity polarity: 0 odd, 1 even |
| line_hi_o | output | 1 | Ones line |
| line_lo_o | output | 1 | Zeros line |
| ready_o | output | 1 | Queue empty and shifter idle |
| half_o | output | 1 | 16 or more words stored |
| full_o | output | 1 | 32 words stored |

## Verification
The hardest state to reach from the ports is a full queue that also has a transmission pending. To get there, the bench holds the send enable low while it appends 32 words, and it reads the half and full flags at the 15th, 16th and 32nd append. It then appends a 33rd, distinct word and drains the queue. The bench decodes every serialized word and confirms that the 33rd word never appears on the lines. A second scenario drops the enable during the first data half of a word. It shows that this word finishes and that the next queued word waits until the enable returns.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_NULL = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  localparam int unsigned GAP_HALVES = 8;  // word gap = four bit times
endpackage

// File: rtl/a429_load_asm.sv
module a429_load_asm #(
  parameter int unsigned HALF_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [HALF_W-1:0]     data_i,
  input  logic                  lo_stb_i,
  input  logic                  hi_stb_i,
  output logic                  push_o,
  output logic [2*HALF_W-1:0]   word_o
);
  logic [HALF_W-1:0] lo_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      pend_q <= 1'b0;
    end else if (lo_stb_i) begin
      lo_q   <= data_i;
      pend_q <= 1'b1;
    end else if (hi_stb_i) begin
      pend_q <= 1'b0;
    end
  end

  assign push_o = hi_stb_i & pend_q;
  assign word_o = {data_i, lo_q};
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             half_o,
  output logic             full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign half_o  = (cnt_q >= HALF_CNT);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q)); // R3
  AST_PUSH_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> cnt_q == $past(cnt_q) + 1'b1); // R1
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R10
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned HALF_FAST = 5,
  parameter int unsigned HALF_SLOW = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             slow_i,
  input  logic             par_en_i,
  input  logic             par_even_i,
  input  logic             avail_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             line_hi_o,
  output logic             line_lo_o
);
  localparam int unsigned HALF_MAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int unsigned CNT_W    = $clog2(GAP_HALVES * HALF_MAX);
  localparam int unsigned IDX_W    = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] HF_LAST = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] HS_LAST = CNT_W'(HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] GF_LAST = CNT_W'(GAP_HALVES * HALF_FAST - 1);
  localparam logic [CNT_W-1:0] GS_LAST = CNT_W'(GAP_HALVES * HALF_SLOW - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIDTH - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q, half_last_q, gap_last_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIDTH-1:0] sh_q;
  logic             start;
  logic             half_end, gap_end;
  logic [WIDTH-1:0] launch_word;

  assign half_end = (cnt_q == half_last_q);
  assign gap_end  = (cnt_q == gap_last_q);
  assign start    = en_i & avail_i &
                    ((state_q == ST_IDLE) | ((state_q == ST_GAP) & gap_end));
  assign pop_o    = start;

  // bit 32 replaced by parity when enabled; data bits 1..31 untouched
  always_comb begin
    launch_word = word_i;
    if (par_en_i) launch_word[WIDTH-1] = ~(^word_i[WIDTH-2:0]) ^ par_even_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      sh_q        <= '0;
      half_last_q <= HF_LAST;
      gap_last_q  <= GF_LAST;
    end else if (start) begin
      state_q     <= ST_DATA;
      cnt_q       <= '0;
      idx_q       <= '0;
      sh_q        <= launch_word;
      half_last_q <= slow_i ? HS_LAST : HF_LAST;
      gap_last_q  <= slow_i ? GS_LAST : GF_LAST;
    end else begin
      unique case (state_q)
        ST_IDLE: cnt_q <= '0;
        ST_DATA: begin
          cnt_q <= half_end ? '0 : cnt_q + 1'b1;
          if (half_end) state_q <= ST_NULL;
        end
        ST_NULL: begin
          cnt_q <= half_end ? '0 : cnt_q + 1'b1;
          if (half_end) begin
            if (idx_q == IDX_LAST) begin
              state_q <= ST_GAP;
            end else begin
              state_q <= ST_DATA;
              idx_q   <= idx_q + 1'b1;
              sh_q    <= sh_q >> 1;
            end
          end
        end
        ST_GAP: begin
          cnt_q <= gap_end ? '0 : cnt_q + 1'b1;
          if (gap_end) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q == ST_DATA) | (state_q == ST_NULL);
  assign line_hi_o = (state_q == ST_DATA) &  sh_q[0];
  assign line_lo_o = (state_q == ST_DATA) & ~sh_q[0];

  AST_BIT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_NULL && half_end && idx_q != IDX_LAST && !start)
      |=> idx_q == $past(idx_q) + 1'b1); // R7
  AST_START_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i)); // R10
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx #(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned HALF_FAST = 5,
  parameter int unsigned HALF_SLOW = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALF_W-1:0] data_i,
  input  logic              lo_stb_i,
  input  logic              hi_stb_i,
  input  logic              send_en_i,
  input  logic              slow_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              line_hi_o,
  output logic              line_lo_o,
  output logic              ready_o,
  output logic              half_o,
  output logic              full_o
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic              push, pop, empty, busy;
  logic [WORD_W-1:0] wr_word, rd_word;

  a429_load_asm #(.HALF_W(HALF_W)) u_asm (
    .clk_i, .rst_ni, .data_i, .lo_stb_i, .hi_stb_i,
    .push_o(push), .word_o(wr_word)
  );

  a429_tx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push), .wdata_i(wr_word), .pop_i(pop),
    .rdata_o(rd_word), .empty_o(empty), .half_o(half_o), .full_o(full_o)
  );

  a429_tx_ser #(.WIDTH(WORD_W), .HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_ser (
    .clk_i, .rst_ni, .en_i(send_en_i), .slow_i, .par_en_i, .par_even_i,
    .avail_i(~empty), .word_i(rd_word), .pop_o(pop), .busy_o(busy),
    .line_hi_o, .line_lo_o
  );

  assign ready_o = empty & ~busy;

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !line_hi_o && !line_lo_o); // R5
  AST_FULL_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o); // R4
  AST_LINES_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({line_hi_o, line_lo_o})); // R6
endmodule

// File: tb/a429_word_tx_tb.sv
module a429_word_tx_tb;
  localparam time CLK_P = 10ns;
  localparam int  HF = 5;
  localparam int  HS = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] data = '0;
  logic        lo_stb = 1'b0, hi_stb = 1'b0, en = 1'b0;
  logic        slow = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic        line_hi, line_lo, ready, half, full;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  a429_word_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .lo_stb_i(lo_stb), .hi_stb_i(hi_stb),
    .send_en_i(en), .slow_i(slow), .par_en_i(par_en), .par_even_i(par_even),
    .line_hi_o(line_hi), .line_lo_o(line_lo), .ready_o(ready), .half_o(half), .full_o(full)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 3)) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] with_par(input logic [31:0] w, input bit even);
    return {~(^w[30:0]) ^ even, w[30:0]};
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk); data = w[15:0]; lo_stb = 1'b1;
    @(negedge clk); lo_stb = 1'b0; data = w[31:16]; hi_stb = 1'b1;
    @(negedge clk); hi_stb = 1'b0;
  endtask

  // count negedges with both lines low until activity (or limit)
  task automatic wait_active(input int lim, output int n);
    n = 0;
    while (!(line_hi || line_lo) && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  // called at the negedge showing the first data cycle of bit 1
  task automatic recv(input int h, output logic [31:0] w, output bit ok);
    ok = 1'b1; w = '0;
    for (int b = 0; b < 32; b++) begin
      for (int c = 0; c < h; c++) begin
        if (c == 0) w[b] = line_hi;
        if (!(line_hi ^ line_lo) || line_hi != w[b]) ok = 1'b0;
        @(negedge clk);
      end
      for (int c = 0; c < h; c++) begin
        if (line_hi || line_lo) ok = 1'b0;
        @(negedge clk);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; en = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    push_word(pat(90)); push_word(pat(91));
    en = 1'b1; repeat (7) @(negedge clk);
    do_reset();
    check(ready === 1'b1, "R11 ready after reset", 32'(ready), 1);
    check(half === 1'b0 && full === 1'b0, "R11 flags after reset", {half, full}, 0);
    check(!line_hi && !line_lo, "R11 lines after reset", {line_hi, line_lo}, 0);
    repeat (20) @(negedge clk);
    check(!line_hi && !line_lo, "R11 nothing sent after reset", {line_hi, line_lo}, 0);
    en = 1'b0;
  endtask

  task automatic t_load_steps();
    @(negedge clk); data = 16'hFFFF; hi_stb = 1'b1;
    @(negedge clk); hi_stb = 1'b0;
    @(negedge clk);
    check(ready === 1'b1, "R2 stray upper strobe ignored", 32'(ready), 1);
    @(negedge clk); data = 16'h1234; lo_stb = 1'b1;
    @(negedge clk); lo_stb = 1'b0;
    @(negedge clk);
    check(ready === 1'b1, "R1 lower half alone not queued", 32'(ready), 1);
    @(negedge clk); data = 16'h8765; hi_stb = 1'b1;
    @(negedge clk); hi_stb = 1'b0;
    check(ready === 1'b0, "R5 ready drops after append", 32'(ready), 0);
    begin
      logic [31:0] w; bit ok;
      en = 1'b1; @(negedge clk);
      check(line_hi || line_lo, "R10 first bit on enable edge", {line_hi, line_lo}, 1);
      check(ready === 1'b0, "R5 ready low while sending", 32'(ready), 0);
      recv(HF, w, ok);
      check(ok, "R6 fast bit timing", 32'(ok), 1);
      check(w === 32'h8765_1234, "R7 R1 word content and order", w, 32'h8765_1234);
      check(ready === 1'b1, "R5 ready after last bit", 32'(ready), 1);
      en = 1'b0;
    end
    repeat (50) @(negedge clk);
  endtask

  task automatic t_parity(input bit even);
    logic [31:0] w, src; bit ok; int n;
    src = even ? 32'h0000_0003 : 32'h8000_0001;
    par_en = 1'b1; par_even = even;
    push_word(src); en = 1'b1;
    wait_active(100, n);
    recv(HF, w, ok);
    check(ok && w === with_par(src, even), even ? "R8 even parity" : "R8 odd parity",
          w, with_par(src, even));
    check((^w) == !even, "R8 ones count parity", 32'(^w), 32'(!even));
    en = 1'b0; par_en = 1'b0; par_even = 1'b0;
    repeat (50) @(negedge clk);
  endtask

  task automatic t_no_parity();
    logic [31:0] w; bit ok; int n;
    push_word(32'h8000_0000); en = 1'b1;
    wait_active(100, n);
    recv(HF, w, ok);
    check(ok && w === 32'h8000_0000, "R8 bit 32 as data", w, 32'h8000_0000);
    en = 1'b0; repeat (50) @(negedge clk);
  endtask

  task automatic t_back_to_back(input bit sl);
    logic [31:0] w; bit ok; int n, h;
    h = sl ? HS : HF; slow = sl;
    push_word(pat(1)); push_word(pat(2)); en = 1'b1;
    wait_active(100, n);
    recv(h, w, ok);
    check(ok && w === pat(1), sl ? "R6 slow word 1" : "R6 fast word 1", w, pat(1));
    wait_active(20 * h, n);
    check(n == 8 * h, sl ? "R9 slow gap" : "R9 fast gap", n, 8 * h);
    recv(h, w, ok);
    check(ok && w === pat(2), "R7 second word", w, pat(2));
    en = 1'b0; slow = 1'b0;
    repeat (8 * h + 10) @(negedge clk);
  endtask

  task automatic t_fill();
    logic [31:0] w; bit ok, all_ok; int n;
    for (int i = 0; i < 32; i++) begin
      push_word(pat(100 + i));
      if (i == 14) check(half === 1'b0, "R4 half low at 15", 32'(half), 0);
      if (i == 15) check(half === 1'b1, "R4 half high at 16", 32'(half), 1);
      if (i == 30) check(full === 1'b0, "R3 not full at 31", 32'(full), 0);
    end
    check(full === 1'b1, "R3 full at 32", 32'(full), 1);
    push_word(32'hDEAD_BEEF);
    check(full === 1'b1, "R3 still full", 32'(full), 1);
    check(!line_hi && !line_lo, "R10 nothing sent while disabled", {line_hi, line_lo}, 0);
    en = 1'b1; all_ok = 1'b1;
    for (int i = 0; i < 32; i++) begin
      wait_active(200, n);
      recv(HF, w, ok);
      if (!ok || w !== pat(100 + i)) begin
        all_ok = 1'b0;
        check(1'b0, "R3 drained word", w, pat(100 + i));
      end
      if (i == 16) check(half === 1'b0, "R4 half low after drain", 32'(half), 0);
    end
    check(all_ok, "R3 all 32 words intact", 32'(all_ok), 1);
    wait_active(100, n);
    check(n == 100, "R3 overflow word never sent", n, 100);
    check(ready === 1'b1, "R5 ready when drained", 32'(ready), 1);
    en = 1'b0;
  endtask

  task automatic t_enable_drop();
    logic [31:0] w; bit ok; int n;
    push_word(pat(7)); push_word(pat(8));
    en = 1'b1; @(negedge clk); en = 1'b0;
    recv(HF, w, ok);
    check(ok && w === pat(7), "R10 word completes after enable drop", w, pat(7));
    wait_active(120, n);
    check(n == 120, "R10 no start while disabled", n, 120);
    check(ready === 1'b0, "R5 ready low with word queued", 32'(ready), 0);
    en = 1'b1; wait_active(10, n);
    recv(HF, w, ok);
    check(ok && w === pat(8), "R10 resumes on enable", w, pat(8));
    en = 1'b0; repeat (50) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check(ready === 1'b1 && !half && !full, "R11 initial flags", {ready, half, full}, 3'b100);
    t_load_steps();
    t_parity(1'b0);
    t_parity(1'b1);
    t_no_parity();
    t_back_to_back(1'b0);
    t_back_to_back(1'b1);
    t_fill();
    t_enable_drop();
    t_reset();
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    finish_run();
  end
endmodule